// File: doc/BRIEF.md
# Serial Command ADC Slave Port

This block is the digital front of a multichannel analog-to-digital converter that a host reaches over a four-wire SPI link. The host lowers the active-low select, clocks eight bits in each direction, and raises the select again. The byte received in a transfer is a command. Its top bits name one of the analog inputs, an internal self-test source, or nothing. At the same time, the block returns the result for the source named in the command of the transfer before. A conversion therefore needs two transfers. The second transfer may already carry the next command.

Conversion values come from a parallel per-channel sample bus, one byte per input. The self-test source always reads 8'h80. The width of the select field is a parameter. A 4-bit field gives eleven inputs, with self-test on code 11. A 5-bit field gives nineteen inputs, with self-test on code 19. The link pins are synchronised into the system clock, so the link must run well below the system clock.

Top module: `spi_adc_slave`

## Requirements
- R1: A transfer is full duplex and MSB first in SPI mode 0. MOSI is sampled on rising SCK. MISO takes its next bit after falling SCK. The first bit is on MISO soon after the select falls.
- R2: The byte returned in a transfer is the result for the command latched at the end of the previous valid transfer.
- R3: With a 4-bit select (command bits [7:4]), codes 0 to 10 return byte k of the sample bus, which is `samples[8k+7:8k]`.
- R4: The self-test code (11 with a 4-bit select) returns 8'h80.
- R5: Codes above the self-test code (12 to 15 with a 4-bit select) act as a null command, and the next transfer returns 8'h00.
- R6: A transfer with any SCK rising-edge count other than exactly 8 leaves the latched command unchanged.
- R7: After reset, the first transfer returns 8'h00.
- R8: MISO is 0 while the select is high.
- R9: With a 5-bit select (command bits [7:3]), codes 0 to 18 return inputs 0 to 18. Code 19 returns 8'h80. Codes 20 to 31 return 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host |
| mosi | input | 1 | Serial command data from host |
| cs_n | input | 1 | Active-low select |
| samples | input | N_AIN*8 | Per-channel conversion bytes, channel 0 in the low byte |
| miso | output | 1 | Serial response data to host, registered |

## Verification
A sweep over all eleven input codes uses a distinct byte per channel. This shows that each code picks its own byte and that each answer arrives one transfer late. Alternating 8'h55 and 8'hAA samples expose bit-order or shift-phase slips. Transfers of five and ten clocks between valid ones show whether a malformed length can move the latched command. A second build with a 5-bit select tests a high input, the relocated self-test code and a null code.

// File: rtl/spi_adc_pkg.sv
package spi_adc_pkg;
  localparam logic [7:0] SELFTEST_BYTE = 8'h80;
  localparam logic [7:0] NULL_BYTE     = 8'h00;

  // analog input count for a given select field width
  function automatic int ain_count(input int sel_w);
    return (sel_w == 5) ? 19 : 11;
  endfunction
endpackage

// File: rtl/spi_adc_sync.sv
module spi_adc_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_in;
      else stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
    end
  end

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_adc_shifter.sv
module spi_adc_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_low,
  input  logic              cs_fall,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] load_data,
  output logic              miso,
  output logic [DATA_W-1:0] rx_byte,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      miso    <= 1'b0;
    end else if (cs_fall) begin
      tx_sr   <= load_data;
      bit_cnt <= '0;
      miso    <= load_data[DATA_W-1];
    end else if (!cs_low) begin
      miso    <= 1'b0;
    end else begin
      if (sck_rise) begin
        rx_byte <= {rx_byte[DATA_W-2:0], mosi_s};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
      if (sck_fall) begin
        tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
        miso  <= tx_sr[DATA_W-2];
      end
    end
  end

  // R1
  miso_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_low && !cs_fall && !sck_fall) |=> $stable(miso));

  // R8
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_low && !$past(cs_low)) |=> (miso == 1'b0));
endmodule

// File: rtl/spi_adc_resp.sv
module spi_adc_resp
  import spi_adc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  parameter int CNT_W  = 4,
  parameter int N_AIN  = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_rise,
  input  logic [CNT_W-1:0]        bit_cnt,
  input  logic [DATA_W-1:0]       rx_byte,
  input  logic [N_AIN*DATA_W-1:0] samples,
  output logic [SEL_W-1:0]        pend_sel,
  output logic [DATA_W-1:0]       resp_byte
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
  localparam logic [SEL_W-1:0] ST_CODE  = SEL_W'(N_AIN);

  logic [DATA_W-1:0] ain_byte [N_AIN];

  for (genvar c = 0; c < N_AIN; c++) begin : g_ain
    assign ain_byte[c] = samples[c*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) pend_sel <= '1;
    else if (cs_rise && bit_cnt == FULL_CNT)
      pend_sel <= rx_byte[DATA_W-1 -: SEL_W];
  end

  always_comb begin
    if (pend_sel == ST_CODE)            resp_byte = SELFTEST_BYTE;
    else if (int'(pend_sel) < N_AIN)    resp_byte = ain_byte[int'(pend_sel)];
    else                                resp_byte = NULL_BYTE;
  end

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_sel != $past(pend_sel)) |-> $past(cs_rise && bit_cnt == FULL_CNT));
endmodule

// File: rtl/spi_adc_slave.sv
module spi_adc_slave
  import spi_adc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 4,
  parameter int SYNC_ST = 2,
  parameter int N_AIN   = ain_count(SEL_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sck,
  input  logic                    mosi,
  input  logic                    cs_n,
  input  logic [N_AIN*DATA_W-1:0] samples,
  output logic                    miso
);
  localparam int CNT_W = $clog2(DATA_W) + 1;
  localparam logic [SEL_W-1:0] ST_CODE = SEL_W'(N_AIN);

  logic [2:0] pins_s;
  logic sck_s, mosi_s, cs_s, sck_q, cs_q;
  logic sck_rise, sck_fall, cs_fall, cs_rise;
  logic [DATA_W-1:0] rx_byte, resp_byte;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SEL_W-1:0]  pend_sel;

  spi_adc_sync #(.W(3), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d_in({cs_n, mosi, sck}), .q_out(pins_s));

  assign {cs_s, mosi_s, sck_s} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign cs_rise  = cs_s & ~cs_q;

  spi_adc_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .cs_low(~cs_s), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .load_data(resp_byte), .miso(miso), .rx_byte(rx_byte), .bit_cnt(bit_cnt));

  spi_adc_resp #(.DATA_W(DATA_W), .SEL_W(SEL_W), .CNT_W(CNT_W), .N_AIN(N_AIN)) u_resp (
    .clk(clk), .rst(rst), .cs_rise(cs_rise), .bit_cnt(bit_cnt),
    .rx_byte(rx_byte), .samples(samples), .pend_sel(pend_sel),
    .resp_byte(resp_byte));

  // R4
  selftest_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && pend_sel == ST_CODE) |=> (miso == 1'b1));

  // R5
  null_msb_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && int'(pend_sel) > N_AIN) |=> (miso == 1'b0));
endmodule

// File: tb/spi_adc_slave_tb.sv
module spi_adc_slave_tb;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1, cs_w = 1'b1;
  logic [11*8-1:0] samples;
  logic [19*8-1:0] samples_w;
  logic miso, miso_w;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_adc_slave u_dut (.clk(clk), .rst(rst), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .samples(samples), .miso(miso));

  spi_adc_slave #(.SEL_W(5)) u_wide (.clk(clk), .rst(rst), .sck(sck),
    .mosi(mosi), .cs_n(cs_w), .samples(samples_w), .miso(miso_w));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input bit wide, input logic [7:0] cmd, input int nclk,
                      output logic [7:0] rx);
    rx = '0;
    if (wide) cs_w = 1'b0; else cs_n = 1'b0;
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 8) ? cmd[7-i] : 1'b0;
      wclk(HALF);
      if (i < 8) rx = {rx[6:0], wide ? miso_w : miso};
      sck = 1'b1;
      wclk(HALF);
      sck = 1'b0;
    end
    wclk(HALF);
    cs_n = 1'b1;
    cs_w = 1'b1;
    wclk(HALF);
  endtask

  function automatic logic [7:0] cmd4(input int code);
    return 8'(code << 4);
  endfunction

  task automatic t_reset();
    logic [7:0] r;
    wclk(4);
    chk("R8 idle miso", {7'd0, miso}, 8'h00);
    xfer(0, cmd4(2), 8, r);
    chk("R7 first transfer", r, 8'h00);
    wclk(2);
    chk("R8 miso after transfer", {7'd0, miso}, 8'h00);
  endtask

  task automatic t_channels();
    logic [7:0] r;
    for (int c = 0; c <= 10; c++) begin
      xfer(0, cmd4(c), 8, r);
      if (c == 0) chk("R2 result of previous command", r, samples[2*8 +: 8]);
      else chk("R3 channel sweep", r, samples[(c-1)*8 +: 8]);
    end
    xfer(0, cmd4(0), 8, r);
    chk("R3 channel 10", r, samples[10*8 +: 8]);
  endtask

  task automatic t_pattern();
    logic [7:0] r;
    samples[4*8 +: 8] = 8'h55;
    samples[5*8 +: 8] = 8'hAA;
    xfer(0, cmd4(4), 8, r);
    xfer(0, cmd4(5), 8, r);
    chk("R1 pattern 55", r, 8'h55);
    xfer(0, cmd4(1), 8, r);
    chk("R1 pattern AA", r, 8'hAA);
  endtask

  task automatic t_selftest_null();
    logic [7:0] r;
    xfer(0, cmd4(11), 8, r);
    xfer(0, cmd4(12), 8, r);
    chk("R4 self-test", r, 8'h80);
    xfer(0, cmd4(15), 8, r);
    chk("R5 null code 12", r, 8'h00);
    xfer(0, cmd4(6), 8, r);
    chk("R5 null code 15", r, 8'h00);
    xfer(0, cmd4(6), 8, r);
    chk("R2 after null", r, samples[6*8 +: 8]);
  endtask

  task automatic t_length();
    logic [7:0] r;
    xfer(0, cmd4(3), 8, r);
    xfer(0, cmd4(7), 5, r);
    xfer(0, cmd4(0), 8, r);
    chk("R6 short transfer ignored", r, samples[3*8 +: 8]);
    xfer(0, cmd4(7), 10, r);
    xfer(0, cmd4(1), 8, r);
    chk("R6 long transfer ignored", r, samples[0 +: 8]);
    xfer(0, cmd4(2), 8, r);
    chk("R6 normal after long", r, samples[1*8 +: 8]);
  endtask

  task automatic t_wide();
    logic [7:0] r;
    xfer(1, 8'(17 << 3), 8, r);
    chk("R9 wide first", r, 8'h00);
    xfer(1, 8'(19 << 3), 8, r);
    chk("R9 wide channel 17", r, samples_w[17*8 +: 8]);
    xfer(1, 8'(25 << 3), 8, r);
    chk("R9 wide self-test", r, 8'h80);
    xfer(1, 8'(18 << 3), 8, r);
    chk("R9 wide null", r, 8'h00);
    xfer(1, 8'(0 << 3), 8, r);
    chk("R9 wide channel 18", r, samples_w[18*8 +: 8]);
  endtask

  initial begin
    for (int c = 0; c < 11; c++) samples[c*8 +: 8] = 8'(8'h11 + c * 8'h17);
    for (int c = 0; c < 19; c++) samples_w[c*8 +: 8] = 8'(8'h23 + c * 8'h0D);
    wclk(5);
    rst = 1'b0;
    t_reset();
    t_channels();
    t_pattern();
    t_selftest_null();
    t_length();
    t_wide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule